// File: doc/BRIEF.md
# Video-Mode Display Timing Generator

This block produces the free-running timing of a video-mode display. It drives horizontal and vertical sync, a data-enable strobe, and the raw pixel and line counters. Each line is made of four phases in a fixed order: sync, back porch, active pixels and front porch. Each frame follows the same four-phase order, counted in lines.

Software reaches a small register file over a plain write strobe and a combinational read port. It writes geometry into a working copy. The counters use an active copy, which takes the working values only after software asks for an update. When the generator runs, that copy happens at the frame boundary. When it is stopped, the copy happens at once.

A stop request lets the frame in flight finish before output goes idle. Done, tearing-effect, underflow, update-done and vsync events latch into a status register. Software clears that register by writing ones. Each status bit has its own enable into a single interrupt line.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, hsync_o, vsync_o, de_o, irq_o and both counters are 0. The control and status registers read 0. The working timing registers hold the parameter defaults.
- R2: While running, pix_x_o counts 0 to line_total-1, where line_total = sync + back porch + active + front porch. line_y_o advances at each line end and wraps after its own total. hsync_o is high (default polarity) while pix_x_o < hsync length.
- R3: de_o is high only when pix_x_o lies in [hsync+hbp, hsync+hbp+width) and line_y_o lies in [vsync+vbp, vsync+vbp+height).
- R4: vsync_o is high (default polarity) while line_y_o < vsync length.
- R5: Writes to the size (word 1: width [15:0], height [31:16]) and timing registers (word 2 horizontal, word 3 vertical: sync [7:0], back porch [19:8], front porch [31:20]) do not change the output timing on their own. Writing control (word 0) bit 2 while running applies them at the next frame boundary and sets status bit 4.
- R6: An update request while stopped applies on the next clock and sets status bit 4.
- R7: Control bit 0 starts the generator at pixel 0, line 0. Control bit 1, while running, lets the current frame complete, then forces all outputs and counters to 0 and sets status bit 0.
- R8: Status bit 5 is set at every frame boundary while running.
- R9: underflow_i sets status bit 2 only while running. te_i sets status bit 1.
- R10: Writing word 5 clears the status bits (word 6) where the written data has ones, and 0xFF clears all. A status event in the same cycle wins over the clear.
- R11: irq_o is high exactly when some status bit and its enable bit (word 4) are both set. Status bits latch even while their enable is clear.
- R12: Control bits act once and do not stay stored. A read of word 0 returns running in bit 0, stop pending in bit 1 and update pending in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| te_i | input | 1 | Tearing-effect event |
| underflow_i | input | 1 | Upstream pixel FIFO underflow |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | 18 | Pixel counter within the line |
| line_y_o | output | 18 | Line counter within the frame |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things. The counters stay below their configured totals and both return to zero after a frame end. The active geometry holds still except on an update apply, and the generator halts on the cycle after a pending stop meets a frame end. For status, they check that an event always lands in the register and that the register holds when there is neither event nor clear. The exact sync and data-enable waveforms per pixel, the one-frame delay of an update, the number of active pixels drawn after a stop request, and the masking of the interrupt line can only be shown by the bench's directed frames.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int DIM_W   = 16;
  localparam int SYNC_W  = 8;
  localparam int PORCH_W = 12;
  localparam int CNT_W   = DIM_W + 2;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int IRQ_W   = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_SIZE = 3'd1;
  localparam logic [ADDR_W-1:0] A_HTIM = 3'd2;
  localparam logic [ADDR_W-1:0] A_VTIM = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ICLR = 3'd5;
  localparam logic [ADDR_W-1:0] A_ISTS = 3'd6;

  localparam int C_RUN  = 0;
  localparam int C_STOP = 1;
  localparam int C_UPD  = 2;

  localparam int I_DONE = 0;
  localparam int I_TE   = 1;
  localparam int I_UFL  = 2;
  localparam int I_UPD  = 4;
  localparam int I_VS   = 5;

  typedef struct packed {
    logic [DIM_W-1:0]   act;
    logic [SYNC_W-1:0]  sync;
    logic [PORCH_W-1:0] bp;
    logic [PORCH_W-1:0] fp;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t h;
    axis_cfg_t v;
  } tcfg_t;
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  axis_cfg_t        cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             sync_o,
  output logic             act_o
);
  logic [CNT_W-1:0] act_lo, act_hi, tot;

  assign act_lo = CNT_W'(cfg_i.sync) + CNT_W'(cfg_i.bp);
  assign act_hi = act_lo + CNT_W'(cfg_i.act);
  assign tot    = act_hi + CNT_W'(cfg_i.fp);

  assign last_o = run_i && (cnt_o == tot - CNT_W'(1));
  assign sync_o = run_i && (cnt_o < CNT_W'(cfg_i.sync));
  assign act_o  = run_i && (cnt_o >= act_lo) && (cnt_o < act_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (!run_i) cnt_o <= '0;
    else if (step_i) cnt_o <= last_o ? '0 : cnt_o + CNT_W'(1);
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tot != '0) |-> (cnt_o < tot));
  p_stop_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0));
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter tcfg_t RST_CFG = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              running_i,
  input  logic              stop_pend_i,
  input  logic              upd_pend_i,
  input  logic [IRQ_W-1:0]  sts_i,
  output tcfg_t             work_o,
  output logic [IRQ_W-1:0]  ien_o,
  output logic              run_req_o,
  output logic              stop_req_o,
  output logic              upd_req_o,
  output logic [IRQ_W-1:0]  clr_o
);
  logic wr_ctrl;

  assign wr_ctrl    = we_i && (addr_i == A_CTRL);
  assign run_req_o  = wr_ctrl && wdata_i[C_RUN];
  assign stop_req_o = wr_ctrl && wdata_i[C_STOP];
  assign upd_req_o  = wr_ctrl && wdata_i[C_UPD];
  assign clr_o      = (we_i && addr_i == A_ICLR) ? wdata_i[IRQ_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_o <= RST_CFG;
      ien_o  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_SIZE: begin
          work_o.h.act <= wdata_i[15:0];
          work_o.v.act <= wdata_i[31:16];
        end
        A_HTIM: begin
          work_o.h.sync <= wdata_i[7:0];
          work_o.h.bp   <= wdata_i[19:8];
          work_o.h.fp   <= wdata_i[31:20];
        end
        A_VTIM: begin
          work_o.v.sync <= wdata_i[7:0];
          work_o.v.bp   <= wdata_i[19:8];
          work_o.v.fp   <= wdata_i[31:20];
        end
        A_IEN:   ien_o <= wdata_i[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[2:0] = {upd_pend_i, stop_pend_i, running_i};
      A_SIZE: rdata_o = {work_o.v.act, work_o.h.act};
      A_HTIM: rdata_o = {work_o.h.fp, work_o.h.bp, work_o.h.sync};
      A_VTIM: rdata_o = {work_o.v.fp, work_o.v.bp, work_o.v.sync};
      A_IEN:  rdata_o[IRQ_W-1:0] = ien_o;
      A_ISTS: rdata_o[IRQ_W-1:0] = sts_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
#(
  parameter tcfg_t RST_CFG = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_req_i,
  input  logic  stop_req_i,
  input  logic  upd_req_i,
  input  logic  eof_i,
  input  tcfg_t work_i,
  output tcfg_t act_o,
  output logic  running_o,
  output logic  stop_pend_o,
  output logic  upd_pend_o,
  output logic  done_ev_o,
  output logic  upd_ev_o
);
  logic halt, apply;

  assign halt      = eof_i && stop_pend_o;
  assign apply     = upd_pend_o && (!running_o || eof_i);
  assign done_ev_o = halt;
  assign upd_ev_o  = apply;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_o   <= 1'b0;
      stop_pend_o <= 1'b0;
    end else if (halt) begin
      running_o   <= 1'b0;
      stop_pend_o <= 1'b0;
    end else begin
      if (run_req_i && !running_o) running_o   <= 1'b1;
      if (stop_req_i && running_o) stop_pend_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o      <= RST_CFG;
      upd_pend_o <= 1'b0;
    end else begin
      if (apply) act_o <= work_i;
      upd_pend_o <= upd_req_i || (upd_pend_o && !apply);
    end
  end

  p_act_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> $stable(act_o));
  p_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> !running_o);
  p_stop_needs_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_pend_o |-> running_o);
  p_upd_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_pend_o && !running_o) |=> !upd_pend_o || $past(upd_req_i));
endmodule

// File: rtl/dtg_irq.sv
module dtg_irq
  import dtg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] set_i,
  input  logic [IRQ_W-1:0] clr_i,
  input  logic [IRQ_W-1:0] en_i,
  output logic [IRQ_W-1:0] sts_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_i) | set_i;
  end

  assign irq_o = |(sts_o & en_i);

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(sts_o));
  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((sts_o & $past(clr_i)) == '0));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int DEF_W   = 4,
  parameter int DEF_H   = 3,
  parameter int DEF_HS  = 1,
  parameter int DEF_HBP = 1,
  parameter int DEF_HFP = 1,
  parameter int DEF_VS  = 1,
  parameter int DEF_VBP = 1,
  parameter int DEF_VFP = 1,
  parameter bit HS_POL  = 1'b1,
  parameter bit VS_POL  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              te_i,
  input  logic              underflow_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [CNT_W-1:0]  pix_x_o,
  output logic [CNT_W-1:0]  line_y_o,
  output logic              irq_o
);
  localparam tcfg_t DEF_CFG = '{
    h: '{act: DIM_W'(DEF_W), sync: SYNC_W'(DEF_HS), bp: PORCH_W'(DEF_HBP), fp: PORCH_W'(DEF_HFP)},
    v: '{act: DIM_W'(DEF_H), sync: SYNC_W'(DEF_VS), bp: PORCH_W'(DEF_VBP), fp: PORCH_W'(DEF_VFP)}
  };

  tcfg_t            work, act;
  logic [IRQ_W-1:0] ien, clr, sts, set;
  logic             run_req, stop_req, upd_req;
  logic             running, stop_pend, upd_pend, done_ev, upd_ev;
  logic             h_last, v_last, h_sync, v_sync, h_act, v_act, eof;

  dtg_regs #(.RST_CFG(DEF_CFG)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .running_i(running), .stop_pend_i(stop_pend), .upd_pend_i(upd_pend),
    .sts_i(sts), .work_o(work), .ien_o(ien),
    .run_req_o(run_req), .stop_req_o(stop_req), .upd_req_o(upd_req),
    .clr_o(clr)
  );

  dtg_ctrl #(.RST_CFG(DEF_CFG)) u_ctrl (
    .clk_i, .rst_ni,
    .run_req_i(run_req), .stop_req_i(stop_req), .upd_req_i(upd_req),
    .eof_i(eof), .work_i(work), .act_o(act),
    .running_o(running), .stop_pend_o(stop_pend), .upd_pend_o(upd_pend),
    .done_ev_o(done_ev), .upd_ev_o(upd_ev)
  );

  dtg_axis u_h (
    .clk_i, .rst_ni, .run_i(running), .step_i(1'b1), .cfg_i(act.h),
    .cnt_o(pix_x_o), .last_o(h_last), .sync_o(h_sync), .act_o(h_act)
  );

  dtg_axis u_v (
    .clk_i, .rst_ni, .run_i(running), .step_i(h_last), .cfg_i(act.v),
    .cnt_o(line_y_o), .last_o(v_last), .sync_o(v_sync), .act_o(v_act)
  );

  assign eof = h_last && v_last;

  always_comb begin
    set         = '0;
    set[I_DONE] = done_ev;
    set[I_TE]   = te_i;
    set[I_UFL]  = underflow_i && running;
    set[I_UPD]  = upd_ev;
    set[I_VS]   = eof;
  end

  dtg_irq u_irq (
    .clk_i, .rst_ni, .set_i(set), .clr_i(clr), .en_i(ien),
    .sts_o(sts), .irq_o
  );

  assign hsync_o = HS_POL ? h_sync : !h_sync;
  assign vsync_o = VS_POL ? v_sync : !v_sync;
  assign de_o    = h_act && v_act;

  p_de_running_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> running);
  p_eof_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof |=> (pix_x_o == '0 && line_y_o == '0));
  p_vs_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof |=> sts[I_VS]);
endmodule

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        te_i = 1'b0, underflow_i = 1'b0;
  logic        hsync_o, vsync_o, de_o, irq_o;
  logic [17:0] pix_x_o, line_y_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  disp_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i, .addr_i, .wdata_i, .rdata_o,
    .te_i, .underflow_i, .hsync_o, .vsync_o, .de_o, .pix_x_o, .line_y_o, .irq_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #2;
    d = rdata_o;
  endtask

  task automatic wait_sof();
    int n = 0;
    @(negedge clk);
    while (!(pix_x_o == 0 && line_y_o == 0) && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_frame(input int hs, hb, w, hf, vs, vb, h, vf, input string req);
    int ht = hs + hb + w + hf;
    int vt = vs + vb + h + vf;
    for (int y = 0; y < vt; y++) begin
      for (int x = 0; x < ht; x++) begin
        bit eh = (x < hs);
        bit ev = (y < vs);
        bit ed = (x >= hs + hb) && (x < hs + hb + w) && (y >= vs + vb) && (y < vs + vb + h);
        logic [63:0] a = (64'(pix_x_o) << 32) | (64'(line_y_o) << 8) | {61'd0, hsync_o, vsync_o, de_o};
        logic [63:0] e = (64'(x) << 32) | (64'(y) << 8) | {61'd0, eh, ev, ed};
        chk(a == e, req, "timing x/y/hs/vs/de", a, e);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk({hsync_o, vsync_o, de_o, irq_o} == 4'b0, "R1", "outputs", {hsync_o, vsync_o, de_o, irq_o}, 0);
    chk(pix_x_o == 0 && line_y_o == 0, "R1", "counters", {pix_x_o, line_y_o}, 0);
    rd(3'd0, d); chk(d == 0, "R1", "ctrl", d, 0);
    rd(3'd6, d); chk(d == 0, "R1", "status", d, 0);
    rd(3'd2, d); chk(d == 32'h0010_0101, "R1", "htim default", d, 32'h0010_0101);
  endtask

  task automatic t_run_default();
    logic [31:0] d;
    wr(3'd0, 32'h1);
    check_frame(1, 1, 4, 1, 1, 1, 3, 1, "R2 R3 R4 R7");
    check_frame(1, 1, 4, 1, 1, 1, 3, 1, "R2 R3 R4");
    rd(3'd6, d); chk(d[5] == 1'b1, "R8", "vsync status", d, 32'h20);
    rd(3'd0, d); chk(d == 32'h1, "R12", "ctrl running only", d, 1);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    wr(3'd2, 32'h0010_0202);
    wait_sof();
    check_frame(1, 1, 4, 1, 1, 1, 3, 1, "R5 no update");
    wr(3'd0, 32'h4);
    rd(3'd0, d); chk(d == 32'h5, "R12", "update pending", d, 5);
    chk(pix_x_o == 1 && line_y_o == 0, "R5", "old frame continues", pix_x_o, 1);
    wait_sof();
    check_frame(2, 2, 4, 1, 1, 1, 3, 1, "R5 applied");
    rd(3'd6, d); chk(d[4] == 1'b1, "R5", "update done", d, 32'h10);
    rd(3'd0, d); chk(d == 32'h1, "R12", "update self clear", d, 1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(3'd5, 32'hFF);
    rd(3'd6, d); chk(d == 0, "R10", "clear all", d, 0);
    wr(3'd4, 32'h20);
    chk(irq_o == 1'b0, "R11", "irq low", irq_o, 0);
    wait_sof();
    chk(irq_o == 1'b1, "R11", "irq on vsync", irq_o, 1);
    wr(3'd5, 32'h01);
    rd(3'd6, d); chk(d == 32'h20, "R10", "selective clear", d, 32'h20);
    chk(irq_o == 1'b1, "R11", "irq kept", irq_o, 1);
    wr(3'd5, 32'h20);
    chk(irq_o == 1'b0, "R10", "irq cleared", irq_o, 0);
    te_i = 1'b1; @(negedge clk); te_i = 1'b0;
    rd(3'd6, d); chk(d[1] == 1'b1, "R9", "te latched", d, 2);
    chk(irq_o == 1'b0, "R11", "masked status", irq_o, 0);
    underflow_i = 1'b1; @(negedge clk); underflow_i = 1'b0;
    rd(3'd6, d); chk(d[2] == 1'b1, "R9", "underflow running", d, 4);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    int n = 0, de_cnt = 0;
    wr(3'd4, 32'h01);
    wr(3'd5, 32'hFF);
    wait_sof();
    wr(3'd0, 32'h2);
    rd(3'd0, d); chk(d == 32'h3, "R7", "stop pending", d, 3);
    while (!irq_o && n < 400) begin
      if (de_o) de_cnt++;
      @(negedge clk);
      n++;
    end
    chk(de_cnt == 12, "R7", "frame finished", de_cnt, 12);
    rd(3'd6, d); chk(d[0] == 1'b1, "R7", "done status", d, 1);
    rd(3'd0, d); chk(d == 0, "R12", "ctrl idle", d, 0);
    for (int i = 0; i < 10; i++) begin
      chk({hsync_o, vsync_o, de_o} == 0 && pix_x_o == 0 && line_y_o == 0, "R7", "idle outputs",
          {hsync_o, vsync_o, de_o, pix_x_o}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_idle_update();
    logic [31:0] d;
    wr(3'd4, 32'h00);
    wr(3'd5, 32'hFF);
    underflow_i = 1'b1; @(negedge clk); underflow_i = 1'b0;
    rd(3'd6, d); chk(d == 0, "R9", "underflow ignored stopped", d, 0);
    wr(3'd1, 32'h0002_0003);
    wr(3'd0, 32'h4);
    rd(3'd0, d); chk(d == 32'h4, "R6", "pending", d, 4);
    @(negedge clk);
    rd(3'd0, d); chk(d == 0, "R6", "applied", d, 0);
    rd(3'd6, d); chk(d == 32'h10, "R6", "update done", d, 32'h10);
    wr(3'd0, 32'h1);
    check_frame(2, 2, 3, 1, 1, 1, 2, 1, "R6 new size");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_default();
    t_shadow();
    t_irq();
    t_stop();
    t_idle_update();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule